// File: doc/BRIEF.md
# Demodulated I/Q Bit Output Formatter

This block sits behind a phase demodulator. Once per symbol it receives one hard-decision bit from the in-phase channel and one from the quadrature channel. It emits these bits in two ways. The first is a serial stream on one pin, paced by a bit-rate clock enable and qualified by a one-cycle valid strobe. The second is a pair of registered parallel outputs that hold the I and Q decisions for the whole symbol.

A three-bit control word sets the output format. Bit 0 (`rev`) chooses the channel order, or the single channel to output. Bit 1 (`bpsk`) chooses one bit per symbol instead of two. Bit 2 (`inv`) complements every output bit. The control word is captured at each symbol strobe, together with the decision bits. A change to the control word between strobes therefore never splits or alters the bit pair of a symbol already in progress.

In two-bit mode, the first serial bit appears on the clock edge that samples the symbol strobe. The second bit follows on the first later edge that samples the bit clock enable high. If a new symbol strobe arrives while a second bit is still pending, the pending bit is discarded and the new symbol starts.

Top module: `iq_bit_formatter`

## Requirements
- R1: A synchronous active-high `rst` drives `ser_bit`, `ser_vld`, `i_out` and `q_out` to 0 on the next clock edge. It also discards any pending second bit, so a later `bit_ce` produces no `ser_vld`.
- R2: With `cfg_reg[1]=0` and `cfg_reg[0]=0`, the edge that samples `sym_stb` outputs the I bit on `ser_bit`. The next edge that samples `bit_ce=1` (with `sym_stb=0`) outputs the Q bit.
- R3: With `cfg_reg[1]=0` and `cfg_reg[0]=1`, the Q bit is output first at the strobe edge. The I bit is output second, at the next `bit_ce` edge.
- R4: With `cfg_reg[1]=1` and `cfg_reg[0]=0`, only the I bit is output, at the strobe edge. A following `bit_ce` produces no `ser_vld`.
- R5: With `cfg_reg[1]=1` and `cfg_reg[0]=1`, only the Q bit is output, at the strobe edge. A following `bit_ce` produces no `ser_vld`.
- R6: When `cfg_reg[2]=1` at the strobe, the serial bits and `i_out`/`q_out` for that symbol are the complements of the decision bits. When `cfg_reg[2]=0`, they are equal to the decision bits.
- R7: `ser_vld` is high for exactly one cycle per output bit: twice per symbol in two-bit mode and once in one-bit mode. It is low in every other cycle.
- R8: `cfg_reg`, `i_bit` and `q_bit` are used only on edges that sample `sym_stb=1`. Changing them between strobes alters neither the pending second bit nor `i_out`/`q_out`.
- R9: `i_out` and `q_out` are loaded on each edge that samples `sym_stb=1` and hold their value otherwise.
- R10: A `sym_stb` that arrives while a second bit is pending discards that bit and outputs the new symbol's first bit at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sym_stb | input | 1 | Symbol strobe; captures decisions and control |
| bit_ce | input | 1 | Bit-rate clock enable pacing the second serial bit |
| i_bit | input | 1 | In-phase decision bit |
| q_bit | input | 1 | Quadrature decision bit |
| cfg_reg | input | 3 | Control word: bit 0 reverse, bit 1 one-bit mode, bit 2 invert |
| ser_bit | output | 1 | Serial output bit |
| ser_vld | output | 1 | One-cycle strobe marking a new serial bit |
| i_out | output | 1 | Registered I bit, possibly inverted |
| q_out | output | 1 | Registered Q bit, possibly inverted |

## Verification
Each of the four mode codes is driven with all four I/Q decision combinations. This shows whether the order is swapped or a channel is dropped, which a single symmetric pattern such as 1/1 would hide. Inversion is tested in both one-bit and two-bit modes, so a fault confined to either the serial path or the parallel path shows up. Further sequences change the control word and the decision bits between the strobe and `bit_ce`. Other sequences send back-to-back strobes, or assert reset while a second bit is pending. These separate a correct capture-at-strobe design from one that reads live inputs, or one that lets stale pending bits leak out.

// File: rtl/ofmt_pkg.sv
package ofmt_pkg;

    localparam int CFG_W    = 3;
    localparam int REV_POS  = 0;
    localparam int BPSK_POS = 1;
    localparam int INV_POS  = 2;
    localparam int NCH      = 2;

    typedef struct packed {
        logic inv;
        logic bpsk;
        logic rev;
    } fmt_cfg_t;

    typedef struct packed {
        logic pend;
        logic snd;
        logic bit_o;
        logic vld;
    } ser_state_t;

endpackage

// File: rtl/ofmt_mode_dec.sv
module ofmt_mode_dec
    import ofmt_pkg::*;
(
    input  logic [CFG_W-1:0] cfg_raw,
    output fmt_cfg_t         cfg
);

    always_comb begin
        cfg.rev  = cfg_raw[REV_POS];
        cfg.bpsk = cfg_raw[BPSK_POS];
        cfg.inv  = cfg_raw[INV_POS];
    end

endmodule

// File: rtl/ofmt_chan_reg.sv
module ofmt_chan_reg #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         inv,
    input  logic [N-1:0] din,
    output logic [N-1:0] dout
);

    logic [N-1:0] val_d, val_q, nxt;

    for (genvar g = 0; g < N; g++) begin : g_ch
        assign nxt[g] = din[g] ^ inv;
    end

    always_comb begin
        val_d = val_q;
        if (load) val_d = nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) val_q <= '0;
        else     val_q <= val_d;
    end

    assign dout = val_q;

    AST_PAR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(dout)); // R9

endmodule

// File: rtl/ofmt_serializer.sv
module ofmt_serializer
    import ofmt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     sym_stb,
    input  logic     bit_ce,
    input  logic     i_bit,
    input  logic     q_bit,
    input  fmt_cfg_t cfg,
    output logic     ser_bit,
    output logic     ser_vld
);

    ser_state_t st_d, st_q;
    logic first_raw, second_raw;

    always_comb begin
        first_raw  = cfg.rev ? q_bit : i_bit;
        second_raw = cfg.rev ? i_bit : q_bit;
        st_d       = st_q;
        st_d.vld   = 1'b0;
        if (sym_stb) begin
            st_d.bit_o = first_raw ^ cfg.inv;
            st_d.vld   = 1'b1;
            st_d.pend  = !cfg.bpsk;
            st_d.snd   = second_raw ^ cfg.inv;
        end else if (bit_ce && st_q.pend) begin
            st_d.bit_o = st_q.snd;
            st_d.vld   = 1'b1;
            st_d.pend  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign ser_bit = st_q.bit_o;
    assign ser_vld = st_q.vld;

    AST_QPSK_PEND: assert property (@(posedge clk) disable iff (rst)
        (sym_stb && !cfg.bpsk) |=> st_q.pend); // R2

    AST_BPSK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (sym_stb && cfg.bpsk) |=> !st_q.pend); // R4

    AST_SECOND_OUT: assert property (@(posedge clk) disable iff (rst)
        (st_q.pend && bit_ce && !sym_stb) |=> (ser_vld && !st_q.pend)); // R7

    AST_PREEMPT: assert property (@(posedge clk) disable iff (rst)
        (st_q.pend && sym_stb) |=> ser_vld); // R10

    AST_VLD_CAUSE: assert property (@(posedge clk) disable iff (rst)
        (!sym_stb && !(bit_ce && st_q.pend)) |=> !ser_vld); // R7

endmodule

// File: rtl/iq_bit_formatter.sv
module iq_bit_formatter
    import ofmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sym_stb,
    input  logic             bit_ce,
    input  logic             i_bit,
    input  logic             q_bit,
    input  logic [CFG_W-1:0] cfg_reg,
    output logic             ser_bit,
    output logic             ser_vld,
    output logic             i_out,
    output logic             q_out
);

    fmt_cfg_t     cfg;
    logic [NCH-1:0] par;

    ofmt_mode_dec u_dec (
        .cfg_raw (cfg_reg),
        .cfg     (cfg)
    );

    ofmt_serializer u_ser (
        .clk     (clk),
        .rst     (rst),
        .sym_stb (sym_stb),
        .bit_ce  (bit_ce),
        .i_bit   (i_bit),
        .q_bit   (q_bit),
        .cfg     (cfg),
        .ser_bit (ser_bit),
        .ser_vld (ser_vld)
    );

    ofmt_chan_reg #(.N(NCH)) u_par (
        .clk  (clk),
        .rst  (rst),
        .load (sym_stb),
        .inv  (cfg.inv),
        .din  ({q_bit, i_bit}),
        .dout (par)
    );

    assign i_out = par[0];
    assign q_out = par[1];

    AST_PAR_INV: assert property (@(posedge clk) disable iff (rst)
        sym_stb |=> (i_out == ($past(i_bit) ^ $past(cfg_reg[INV_POS])))); // R6

    AST_SER_SAME_POL: assert property (@(posedge clk) disable iff (rst)
        (sym_stb && !cfg_reg[REV_POS]) |=> (ser_bit == i_out)); // R6

endmodule

// File: tb/iq_bit_formatter_bench.sv
`timescale 1ns/1ps
module iq_bit_formatter_bench;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sym_stb = 1'b0, bit_ce = 1'b0, i_bit = 1'b0, q_bit = 1'b0;
    logic [2:0] cfg_reg = 3'b000;
    logic ser_bit, ser_vld, i_out, q_out;
    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    iq_bit_formatter u_iq_bit_formatter (
        .clk(clk), .rst(rst), .sym_stb(sym_stb), .bit_ce(bit_ce),
        .i_bit(i_bit), .q_bit(q_bit), .cfg_reg(cfg_reg),
        .ser_bit(ser_bit), .ser_vld(ser_vld), .i_out(i_out), .q_out(q_out)
    );

    task automatic chk(string req, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Drive one symbol, check both serial bits and the parallel outputs.
    task automatic run_sym(logic i, logic q, logic [2:0] c, string req);
        logic rev, bp, inv, f, s, ei, eq;
        rev = c[0]; bp = c[1]; inv = c[2];
        f  = (rev ? q : i) ^ inv;
        s  = (rev ? i : q) ^ inv;
        ei = i ^ inv; eq = q ^ inv;
        sym_stb = 1'b1; i_bit = i; q_bit = q; cfg_reg = c;
        step();
        sym_stb = 1'b0;
        chk({req, " first vld"}, ser_vld, 1'b1);
        chk({req, " first bit"}, ser_bit, f);
        chk({req, " R9 i_out"}, i_out, ei);
        chk({req, " R9 q_out"}, q_out, eq);
        step();
        chk({req, " R7 idle vld"}, ser_vld, 1'b0);
        bit_ce = 1'b1;
        step();
        bit_ce = 1'b0;
        chk({req, " R7 second vld"}, ser_vld, !bp);
        if (!bp) chk({req, " second bit"}, ser_bit, s);
        chk({req, " R9 hold i"}, i_out, ei);
        chk({req, " R9 hold q"}, q_out, eq);
        bit_ce = 1'b1;
        step();
        bit_ce = 1'b0;
        chk({req, " R7 no extra vld"}, ser_vld, 1'b0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        step(); step();
        rst = 1'b0;
        chk("R1 ser_bit", ser_bit, 1'b0);
        chk("R1 ser_vld", ser_vld, 1'b0);
        chk("R1 i_out", i_out, 1'b0);
        chk("R1 q_out", q_out, 1'b0);
    endtask

    task automatic t_modes(logic [2:0] c, string req);
        for (int k = 0; k < 4; k++) run_sym(k[0], k[1], c, req);
    endtask

    task automatic t_cfg_midsymbol();
        sym_stb = 1'b1; i_bit = 1'b1; q_bit = 1'b0; cfg_reg = 3'b000;
        step();
        sym_stb = 1'b0;
        cfg_reg = 3'b111; i_bit = 1'b0; q_bit = 1'b1;
        step();
        chk("R8 i_out held", i_out, 1'b1);
        chk("R8 q_out held", q_out, 1'b0);
        bit_ce = 1'b1;
        step();
        bit_ce = 1'b0;
        chk("R8 second vld", ser_vld, 1'b1);
        chk("R8 second bit", ser_bit, 1'b0);
    endtask

    task automatic t_preempt();
        sym_stb = 1'b1; i_bit = 1'b1; q_bit = 1'b0; cfg_reg = 3'b000;
        step();
        sym_stb = 1'b1; i_bit = 1'b0; q_bit = 1'b1; cfg_reg = 3'b001;
        step();
        sym_stb = 1'b0;
        chk("R10 new first vld", ser_vld, 1'b1);
        chk("R10 new first bit", ser_bit, 1'b1);
        bit_ce = 1'b1;
        step();
        bit_ce = 1'b0;
        chk("R10 new second vld", ser_vld, 1'b1);
        chk("R10 new second bit", ser_bit, 1'b0);
        bit_ce = 1'b1;
        step();
        bit_ce = 1'b0;
        chk("R10 old bit dropped", ser_vld, 1'b0);
    endtask

    task automatic t_reset_pending();
        sym_stb = 1'b1; i_bit = 1'b1; q_bit = 1'b1; cfg_reg = 3'b000;
        step();
        sym_stb = 1'b0; rst = 1'b1;
        step();
        rst = 1'b0;
        chk("R1 outputs cleared", ser_bit | i_out | q_out, 1'b0);
        bit_ce = 1'b1;
        step();
        bit_ce = 1'b0;
        chk("R1 pending cleared", ser_vld, 1'b0);
    endtask

    initial begin
        step();
        t_reset();
        t_modes(3'b000, "R2");
        t_modes(3'b001, "R3");
        t_modes(3'b010, "R4");
        t_modes(3'b011, "R5");
        t_modes(3'b100, "R6 qpsk");
        t_modes(3'b101, "R6 qpsk rev");
        t_modes(3'b110, "R6 bpsk");
        t_modes(3'b111, "R6 bpsk q");
        t_cfg_midsymbol();
        t_preempt();
        t_reset_pending();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule